// File: doc/BRIEF.md
# Radix-4 Bead-Coded 4x4 Multiplier

This block multiplies two unsigned 4-bit operands and returns their 8-bit product, with no clock and no state. It holds every intermediate value as radix-4 digits, and it codes each digit as a group of three "beads" in thermometer form. The group patterns 000, 001, 011 and 111 stand for the values 0, 1, 2 and 3.

The multiplier operand is cut into a low 2-bit slice and a high 2-bit slice. Each slice times the full multiplicand gives a partial product of three bead digits, with weights 16, 4 and 1. The high partial product sits one radix-4 place above the low one. Columns of equal weight are combined by merging their thermometer codes, not by a row of binary full adders. Each merged column is then folded back to a 2-bit digit plus a carry into the next column. The four 2-bit digits, concatenated, form the binary product.

Top module: `beadMul4x4`

## Requirements
- R1: For every one of the 256 operand pairs, `product` equals `mcand * mplier` as unsigned integers.
- R2: `product[1:0]` (radix-4 digit 0) equals `(mcand * mplier[1:0]) mod 4`. It takes no carry from any other column.
- R3: With `mcand`=13 and `mplier`=14, `product` is 182, and its radix-4 digits from most significant down are 2, 3, 1, 2.
- R4: If either operand is zero, `product` is zero.
- R5: With both operands at 15, `product` is 225. The carry out of the top radix-4 column is never set.
- R6: When `mplier[1:0]` is 0, `product` equals `4 * (mcand * mplier[3:2])`. This means the high partial product is aligned one radix-4 place up.
- R7: A column sum of 4 or more passes a carry of one into the next column. With `mcand`=15 and `mplier`=5, `product` is 75, radix-4 digits 1, 0, 2, 3.
- R8: Every internal bead group holds only 000, 001, 011 or 111. Each column's digit plus four times its carry-out equals its bead count plus its carry-in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mcand | input | 4 | Unsigned multiplicand |
| mplier | input | 4 | Unsigned multiplier; bits [1:0] form the low slice, bits [3:2] form the high slice |
| product | output | 8 | Unsigned product, four radix-4 digits, most significant first |

## Verification
The block is purely combinational, so each result is due in the same cycle as the operands that produce it. The bench drives a new operand pair on the falling clock edge and records the expected product in a queue. Just after the following rising edge, it pops that entry and compares it with `product`. This gives half a period for settling, and no sample falls on an edge. An exhaustive sweep of all 256 pairs is followed by directed pairs that target digit alignment, carry ripple and the extremes.

// File: rtl/beadPkg.sv
package beadPkg;
  localparam int BEADS     = 3;            // beads per radix-4 digit
  localparam int OPW       = 4;            // operand width
  localparam int SLICEW    = 2;            // bits per multiplier slice
  localparam int PPDIGITS  = 3;            // digits in one partial product
  localparam int OUTDIGITS = 2 * OPW / SLICEW;
  localparam int MERGEW    = 2 * BEADS + 1; // two groups plus carry-in

  typedef logic [BEADS-1:0] beadT;

  function automatic beadT toBeads(input logic [1:0] v);
    return {v == 2'd3, v >= 2'd2, v != 2'd0};
  endfunction

  function automatic logic [1:0] beadsToBin(input beadT g);
    return {g[1], g[0] & ~g[1] | g[2]};
  endfunction

  function automatic logic beadLegal(input beadT g);
    return (g == 3'b000) || (g == 3'b001) || (g == 3'b011) || (g == 3'b111);
  endfunction
endpackage

// File: rtl/beadPartial.sv
module beadPartial
  import beadPkg::*;
(
  input  logic [OPW-1:0]             mcand,
  input  logic [SLICEW-1:0]          sel,
  output logic [PPDIGITS-1:0][BEADS-1:0] beadOut
);
  localparam int PW = 2 * PPDIGITS;
  logic [PW-1:0] rawProd;

  assign rawProd = PW'(mcand) * PW'(sel);

  for (genvar g = 0; g < PPDIGITS; g++) begin : gDigit
    assign beadOut[g] = toBeads(rawProd[2*g +: 2]);
  end

  always_comb begin
    for (int g = 0; g < PPDIGITS; g++) begin
      AST_PARTIAL_LEGAL: assert (beadLegal(beadOut[g])); // R8
    end
    AST_PARTIAL_VALUE: assert (
      16 * $countones(beadOut[2]) + 4 * $countones(beadOut[1]) + $countones(beadOut[0])
      == int'(mcand) * int'(sel)); // R8
  end
endmodule

// File: rtl/beadColumn.sv
module beadColumn
  import beadPkg::*;
(
  input  logic [BEADS-1:0] xBeads,
  input  logic [BEADS-1:0] yBeads,
  input  logic             carryIn,
  output logic [1:0]       digit,
  output logic             carryOut
);
  logic [MERGEW-1:0] merged;
  logic [MERGEW-1:0] withCarry;

  // thermometer merge: count > i+m+1 when x > i and y > m
  always_comb begin
    merged = '0;
    for (int j = 0; j < BEADS; j++) merged[j] = xBeads[j] | yBeads[j];
    for (int i = 0; i < BEADS; i++)
      for (int m = 0; m < BEADS; m++)
        merged[i+m+1] = merged[i+m+1] | (xBeads[i] & yBeads[m]);
  end

  // shift one more bead in for the carry
  always_comb begin
    withCarry[0] = merged[0] | carryIn;
    for (int j = 1; j < MERGEW; j++)
      withCarry[j] = merged[j] | (carryIn & merged[j-1]);
  end

  // fold seven-bead thermometer into digit mod 4 and carry
  assign carryOut = withCarry[3];
  assign digit[1] = (withCarry[1] & ~withCarry[3]) | withCarry[5];
  assign digit[0] = (withCarry[0] & ~withCarry[1]) | (withCarry[2] & ~withCarry[3])
                  | (withCarry[4] & ~withCarry[5]) | withCarry[6];

  always_comb begin
    if (beadLegal(xBeads) && beadLegal(yBeads)) begin
      AST_MERGE_THERMO: assert ($onehot0(withCarry ^ (withCarry >> 1)) && !(withCarry[MERGEW-1] && !withCarry[0])); // R8
      AST_COLUMN_CONSERVE: assert (int'(digit) + 4 * int'(carryOut)
        == $countones(xBeads) + $countones(yBeads) + int'(carryIn)); // R7
    end
  end
endmodule

// File: rtl/beadMul4x4.sv
module beadMul4x4
  import beadPkg::*;
(
  input  logic [3:0] mcand,
  input  logic [3:0] mplier,
  output logic [7:0] product
);
  logic [PPDIGITS-1:0][BEADS-1:0] loBeads;
  logic [PPDIGITS-1:0][BEADS-1:0] hiBeads;
  logic [OUTDIGITS-1:0][1:0]      digits;
  logic [OUTDIGITS-1:0]           carries;   // carries[k] leaves column k

  beadPartial u_ppLo (.mcand(mcand), .sel(mplier[1:0]), .beadOut(loBeads));
  beadPartial u_ppHi (.mcand(mcand), .sel(mplier[3:2]), .beadOut(hiBeads));

  assign digits[0]  = beadsToBin(loBeads[0]);
  assign carries[0] = 1'b0;

  for (genvar k = 1; k < OUTDIGITS; k++) begin : gCol
    beadColumn u_col (
      .xBeads  (k < PPDIGITS ? loBeads[k] : hiBeads[PPDIGITS-1]),
      .yBeads  (k < PPDIGITS ? hiBeads[k-1] : '0),
      .carryIn (carries[k-1]),
      .digit   (digits[k]),
      .carryOut(carries[k])
    );
  end

  assign product = digits;

  always_comb begin
    AST_NO_TOP_CARRY: assert (!carries[OUTDIGITS-1]); // R5
    AST_DIGIT0_LOW: assert (product[1:0] == 2'(mcand * mplier[1:0])); // R2
  end
endmodule

// File: tb/beadMul4x4_tb.sv
module beadMul4x4_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] mcand = '0, mplier = '0;
  logic [7:0] product;
  int checks = 0, fails = 0, cycles = 0;
  logic done = 1'b0;
  int expQ[$];
  string tagQ[$];

  beadMul4x4 u_dut (.mcand(mcand), .mplier(mplier), .product(product));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive at falling edge, compare just after the next rising edge
  task automatic apply(input int b, input int a, input int exp, input string tag);
    @(negedge clk);
    mcand = 4'(b); mplier = 4'(a);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(posedge clk); #1;
    check(tagQ.pop_front(), int'(product), expQ.pop_front());
  endtask

  task automatic finish();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, WATCHDOG);
      finish();
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rstN = 1'b1;
    #1 check("R4 idle zero", int'(product), 0);
    // R1 and R8: exhaustive sweep exercises every bead group and column
    for (int b = 0; b < 16; b++)
      for (int a = 0; a < 16; a++)
        apply(b, a, b * a, "R1 sweep");
    // R2: low digit depends only on the low slice
    for (int a = 0; a < 16; a++) begin
      apply(11, a, 11 * a, "R2 low digit");
      check("R2 digit0", int'(product[1:0]), (11 * (a % 4)) % 4);
    end
    apply(13, 14, 182, "R3 worked example");
    check("R3 digit3", int'(product[7:6]), 2);
    check("R3 digit2", int'(product[5:4]), 3);
    check("R3 digit1", int'(product[3:2]), 1);
    check("R3 digit0", int'(product[1:0]), 2);
    apply(0, 15, 0, "R4 zero mcand");
    apply(15, 0, 0, "R4 zero mplier");
    apply(15, 15, 225, "R5 max operands");
    for (int s = 1; s < 4; s++)
      apply(13, s * 4, 4 * (13 * s), "R6 high slice alignment");
    apply(15, 5, 75, "R7 carry ripple");
    check("R7 digit3", int'(product[7:6]), 1);
    check("R7 digit2", int'(product[5:4]), 0);
    check("R7 digit1", int'(product[3:2]), 2);
    check("R7 digit0", int'(product[1:0]), 3);
    finish();
  end
endmodule